// File: doc/BRIEF.md
# Nibble-Loaded Auto-Increment SRAM Bridge

This block sits on the memory side of a narrow asynchronous host link and turns it into accesses to a byte-wide SRAM. The host has an 8-bit bidirectional data bus, two active-low strobes (read and write) that idle high, and one select line. The select line chooses what a strobe means. With select high, each write strobe delivers four address bits. Six such strobes build a 24-bit byte pointer. With select low, each strobe moves one data byte to or from the SRAM location named by the pointer, and the pointer then steps forward by one.

All host controls pass through a synchroniser into the block clock. The block acts once per strobe, on the edge where the strobe is released. Because the pointer advances on its own, a host moves a whole block of bytes with one address load followed by a run of data strobes. It never drives a full address bus. The SRAM address comes straight from the pointer register. The `CAP_MIB` parameter sets the capacity: 8 MiB by default, with a 4 MiB build also supported. The pointer width follows from that capacity.

Top module: `nib_sram_bridge`

## Requirements
- R1: After reset the pointer is zero, the SRAM write and output enables are high (inactive), and the bridge does not drive the host bus.
- R2: Six write strobes with select high load the pointer. The first strobe supplies address bits 23:20 and the sixth supplies bits 3:0. Each strobe takes its nibble from host data bits 3:0 and ignores bits 7:4. The new pointer appears on the SRAM address once the sixth strobe is released.
- R3: Fewer than six address nibbles leave the pointer, and therefore the SRAM address, unchanged.
- R4: A write strobe with select low stores host data bits 7:0 at the pointer. When the strobe is released, the pointer increments by one.
- R5: A read strobe with select low places the SRAM byte at the pointer on the host bus. When the strobe is released, the pointer increments by one.
- R6: The bridge drives the host bus only while a read strobe is active with select low. A read strobe with select high drives nothing and leaves the pointer alone. The SRAM write and output enables are never low together.
- R7: Any read strobe clears the nibble sequence. The next six address nibbles then form a fresh pointer, whatever partial load came before.
- R8: The pointer holds log2(CAP_MIB)+20 bits. Loaded address bits above that width are dropped, and incrementing past the last byte wraps to zero (0x7FFFFF to 0 at 8 MiB).
- R9: A strobe held low for many clock cycles still causes exactly one pointer update.
- R10: If a read strobe and a write strobe are released on the same clock with select high, the read wins: the nibble is discarded and the sequence clears, even when the write would have been the sixth nibble.
- R11: With CAP_MIB set to 4, the pointer is 22 bits wide. It truncates a loaded address to bits 21:0 and wraps from 0x3FFFFF to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_io | inout | 8 | Host data bus; nibble in bits 3:0 during address loads |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_asel_i | input | 1 | High: strobes carry address nibbles; low: data access |
| sram_addr_o | output | log2(CAP_MIB)+20 | SRAM byte address (the pointer) |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_rdata_i | input | 8 | SRAM read data |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |

## Verification
Two actions can land on the same clock edge: a write release that would shift in an address nibble, and a read release that clears the nibble sequence. The bench loads five nibbles and then holds both strobes low with select high. It releases them on the same clock, with a write nibble that would otherwise complete the address. The outcome is judged at the ports. The SRAM address must not change. A following clean six-nibble load must then land exactly on its own address, which shows that the read cleared the sequence and the write was dropped.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  localparam int HOST_W     = 8;
  localparam int NIB_W      = 4;
  localparam int NIB_CNT    = 6;
  localparam int LOAD_W     = NIB_W * NIB_CNT;
  localparam int NIB_CNT_W  = $clog2(NIB_CNT);

  // bit order of the synchronised control word
  typedef struct packed {
    logic asel;
    logic wr_n;
    logic rd_n;
  } host_ctl_t;

  function automatic int addr_bits(input int cap_mib);
    return $clog2(cap_mib) + 20;
  endfunction
endpackage

// File: rtl/nsb_sync.sv
module nsb_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  // STAGES flops for metastability plus one for edge detection
  logic [STAGES:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {(STAGES+1){RST_VAL}};
    else         stg_q <= {stg_q[STAGES-1:0], d_i};
  end

  assign q_o    = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/nsb_loader.sv
module nsb_loader
  import nsb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 nib_v_i,
  input  logic [NIB_W-1:0]     nib_i,
  output logic                 load_v_o,
  output logic [LOAD_W-1:0]    load_addr_o,
  output logic [NIB_CNT_W-1:0] cnt_o
);
  localparam int SHADOW_W = LOAD_W - NIB_W;
  localparam logic [NIB_CNT_W-1:0] LAST = NIB_CNT_W'(NIB_CNT - 1);

  logic [NIB_CNT_W-1:0] cnt_q;
  logic [SHADOW_W-1:0]  shadow_q;
  logic                 last;

  assign last        = (cnt_q == LAST);
  assign load_v_o    = nib_v_i & ~clr_i & last;
  assign load_addr_o = {shadow_q, nib_i};
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (nib_v_i) begin
      cnt_q    <= last ? '0 : cnt_q + 1'b1;
      shadow_q <= {shadow_q[SHADOW_W-NIB_W-1:0], nib_i};
    end
  end
endmodule

// File: rtl/nsb_pointer.sv
module nsb_pointer #(
  parameter int ADDR_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_v_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              incr_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (load_v_i) ptr_q <= load_addr_i;
    else if (incr_i)   ptr_q <= ptr_q + 1'b1;  // wraps at capacity
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/nib_sram_bridge.sv
module nib_sram_bridge
  import nsb_pkg::*;
#(
  parameter int CAP_MIB     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = nsb_pkg::addr_bits(CAP_MIB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  inout  wire [7:0]         host_data_io,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic              host_asel_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_wdata_o,
  input  logic [7:0]        sram_rdata_i,
  output logic              sram_we_no,
  output logic              sram_oe_no
);
  host_ctl_t ctl_raw, ctl_s, ctl_p;
  logic rd_rise, wr_rise, mode_data_lvl, mode_data_edge;
  logic nib_v, incr, load_v, bus_oe;
  logic [LOAD_W-1:0]    load_addr;
  logic [NIB_CNT_W-1:0] nib_cnt;
  logic [HOST_W-1:0]    wdata_q;

  assign ctl_raw = '{asel: host_asel_i, wr_n: host_wr_ni, rd_n: host_rd_ni};

  nsb_sync #(
    .W      ($bits(host_ctl_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s),
    .prev_o(ctl_p)
  );

  // release edges; mode at the edge is the mode the strobe was held in
  assign rd_rise        = ctl_s.rd_n & ~ctl_p.rd_n;
  assign wr_rise        = ctl_s.wr_n & ~ctl_p.wr_n;
  assign mode_data_lvl  = ~ctl_s.asel;
  assign mode_data_edge = ~ctl_p.asel;

  assign nib_v = wr_rise & ~mode_data_edge;
  assign incr  = mode_data_edge & (rd_rise | wr_rise);

  // host holds data stable while its strobe is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wdata_q <= '0;
    else if (!host_wr_ni) wdata_q <= host_data_io;
  end

  nsb_loader u_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rd_rise),
    .nib_v_i    (nib_v),
    .nib_i      (wdata_q[NIB_W-1:0]),
    .load_v_o   (load_v),
    .load_addr_o(load_addr),
    .cnt_o      (nib_cnt)
  );

  nsb_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_v_i   (load_v),
    .load_addr_i(load_addr[ADDR_W-1:0]),
    .incr_i     (incr),
    .ptr_o      (sram_addr_o)
  );

  assign bus_oe       = ~ctl_s.rd_n & mode_data_lvl;
  assign host_data_io = bus_oe ? sram_rdata_i : 8'bz;
  assign sram_oe_no   = ~bus_oe;
  assign sram_we_no   = ~(~ctl_s.wr_n & ctl_s.rd_n & mode_data_lvl);
  assign sram_wdata_o = wdata_q;
endmodule

// File: rtl/nsb_bridge_chk.sv
module nsb_bridge_chk #(
  parameter int ADDR_W = 23,
  parameter int CNT_W  = 3,
  parameter int NIBS   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_rise_i,
  input logic              wr_rise_i,
  input logic              mode_data_i,
  input logic              load_v_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_ni,
  input logic              oe_ni
);
  assert_no_we_oe_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_ni && !oe_ni));

  assert_wr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_data_i && wr_rise_i && !rd_rise_i) |=> (addr_i == $past(addr_i) + 1'b1));

  assert_rd_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_data_i && rd_rise_i) |=> (addr_i == $past(addr_i) + 1'b1));

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(NIBS));

  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rise_i |=> (cnt_i == '0));

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_v_i && !(mode_data_i && (rd_rise_i || wr_rise_i))) |=> $stable(addr_i));
endmodule

bind nib_sram_bridge nsb_bridge_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (nsb_pkg::NIB_CNT_W),
  .NIBS  (nsb_pkg::NIB_CNT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_rise_i  (rd_rise),
  .wr_rise_i  (wr_rise),
  .mode_data_i(mode_data_edge),
  .load_v_i   (load_v),
  .cnt_i      (nib_cnt),
  .addr_i     (sram_addr_o),
  .we_ni      (sram_we_no),
  .oe_ni      (sram_oe_no)
);

// File: tb/nib_sram_bridge_tb_top.sv
`timescale 1ns/1ps
module nib_sram_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       rd_n = 1'b1, wr_n = 1'b1, asel = 1'b0;
  logic       drv_en = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] bus8, bus4;

  assign bus8 = drv_en ? drv_val : 8'bz;
  assign bus4 = drv_en ? drv_val : 8'bz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (bus8[i]);
    pullup (bus4[i]);
  end

  logic [22:0] addr8;
  logic [21:0] addr4;
  logic [7:0]  wdata8, rdata8, wdata4;
  logic        we8_n, oe8_n, we4_n, oe4_n;
  logic [7:0]  sram [256];
  logic [7:0]  ref_mem [256];

  nib_sram_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_data_io(bus8),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_asel_i(asel),
    .sram_addr_o(addr8), .sram_wdata_o(wdata8), .sram_rdata_i(rdata8),
    .sram_we_no(we8_n), .sram_oe_no(oe8_n));

  nib_sram_bridge #(.CAP_MIB(4)) dut4_i (
    .clk_i(clk), .rst_ni(rst_n), .host_data_io(bus4),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_asel_i(asel),
    .sram_addr_o(addr4), .sram_wdata_o(wdata4), .sram_rdata_i(8'h00),
    .sram_we_no(we4_n), .sram_oe_no(oe4_n));

  // bench SRAM, aliased on the low address byte
  assign rdata8 = sram[addr8[7:0]];
  always @(posedge clk) if (!we8_n) sram[addr8[7:0]] <= wdata8;

  int n_chk = 0, n_fail = 0;
  logic [22:0] exp8;
  logic [21:0] exp4;
  logic [7:0]  got;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_strobe(input logic a, input logic [7:0] d, input int hold);
    @(negedge clk); asel = a; drv_val = d; drv_en = 1'b1;
    @(negedge clk); wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    drv_en = 1'b0;
  endtask

  task automatic rd_strobe(input logic a, output logic [7:0] d);
    @(negedge clk); asel = a;
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = bus8;
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // MSB nibble first, junk in data bits 7:4
  task automatic load_nibs(input logic [23:0] a, input int count);
    for (int k = 0; k < count; k++) begin
      logic [3:0] nib;
      nib = a[23 - 4*k -: 4];
      wr_strobe(1'b1, {4'($urandom), nib}, 3);
    end
  endtask

  task automatic load_addr(input logic [23:0] a);
    load_nibs(a, 6);
    exp8 = a[22:0];
    exp4 = a[21:0];
  endtask

  task automatic data_write(input logic [7:0] d, input int hold);
    wr_strobe(1'b0, d, hold);
    ref_mem[exp8[7:0]] = d;
    exp8 = exp8 + 1'b1;
    exp4 = exp4 + 1'b1;
  endtask

  task automatic data_read(output logic [7:0] d);
    rd_strobe(1'b0, d);
    exp8 = exp8 + 1'b1;
    exp4 = exp4 + 1'b1;
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      sram[i]    = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    exp8 = '0; exp4 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(addr8 == 0, "R1 addr", 32'(addr8), 0);
    chk(we8_n && oe8_n, "R1 enables", {we8_n, oe8_n}, 2'b11);
    chk(bus8 == 8'hFF, "R1 bus released", bus8, 8'hFF);

    // R2 full load
    load_addr(24'h123456);
    chk(addr8 == exp8, "R2 load", 32'(addr8), 32'(exp8));

    // R3 partial load holds pointer
    load_nibs(24'hABC000, 3);
    chk(addr8 == exp8, "R3 partial load", 32'(addr8), 32'(exp8));

    // R6/R7 address-mode read: no drive, no move, clears sequence
    rd_strobe(1'b1, got);
    chk(got == 8'hFF, "R6 addr-mode read bus", got, 8'hFF);
    chk(addr8 == exp8, "R6 addr-mode read ptr", 32'(addr8), 32'(exp8));
    load_addr(24'h000010);
    chk(addr8 == 23'h10, "R7 fresh load after read", 32'(addr8), 32'h10);

    // R4 write
    data_write(8'hA5, 3);
    chk(sram[8'h10] == 8'hA5, "R4 stored byte", sram[8'h10], 8'hA5);
    chk(addr8 == 23'h11, "R4 increment", 32'(addr8), 32'h11);

    // R9 long strobe, one update
    data_write(8'h3C, 25);
    chk(addr8 == 23'h12, "R9 long strobe", 32'(addr8), 32'h12);
    chk(sram[8'h11] == 8'h3C, "R9 stored byte", sram[8'h11], 8'h3C);

    // R5 reads
    load_addr(24'h000010);
    data_read(got);
    chk(got == 8'hA5, "R5 read byte", got, 8'hA5);
    chk(addr8 == 23'h11, "R5 increment", 32'(addr8), 32'h11);
    data_read(got);
    chk(got == 8'h3C, "R5 read next", got, 8'h3C);
    chk(bus8 == 8'hFF, "R6 bus released after read", bus8, 8'hFF);

    // R8/R11 truncation and wrap
    load_addr(24'hFFFFFF);
    chk(addr8 == 23'h7FFFFF, "R8 truncate", 32'(addr8), 32'h7FFFFF);
    chk(addr4 == 22'h3FFFFF, "R11 truncate", 32'(addr4), 32'h3FFFFF);
    data_write(8'h77, 3);
    chk(addr8 == 0, "R8 wrap", 32'(addr8), 0);
    chk(addr4 == 0, "R11 wrap", 32'(addr4), 0);
    load_addr(24'h3FFFFF);
    data_read(got);
    chk(addr8 == 23'h400000, "R11 no wrap at 8MiB", 32'(addr8), 32'h400000);
    chk(addr4 == 0, "R11 wrap at 4MiB", 32'(addr4), 0);

    // R10 same-edge read and sixth-nibble write in address mode
    load_nibs(24'h54321F, 5);
    @(negedge clk); asel = 1'b1; drv_val = 8'h0E; drv_en = 1'b1;
    @(negedge clk); wr_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (4) @(negedge clk);
    drv_en = 1'b0;
    chk(addr8 == exp8, "R10 nibble dropped", 32'(addr8), 32'(exp8));
    load_addr(24'h000020);
    chk(addr8 == 23'h20, "R10 clean reload", 32'(addr8), 32'h20);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) begin
        load_addr(24'($urandom));
        chk(addr8 == exp8, "R2 random load", 32'(addr8), 32'(exp8));
      end else if (op == 1) begin
        logic [7:0] d;
        d = 8'($urandom_range(0, 254));
        data_write(d, $urandom_range(2, 6));
        chk(addr8 == exp8, "R4 random write ptr", 32'(addr8), 32'(exp8));
      end else begin
        logic [7:0] e;
        e = ref_mem[exp8[7:0]];
        data_read(got);
        chk(got == e, "R5 random read data", got, e);
        chk(addr8 == exp8, "R5 random read ptr", 32'(addr8), 32'(exp8));
      end
      chk(addr4 == exp4, "R11 random ptr", 32'(addr4), 32'(exp4));
    end

    report();
  end
endmodule